// File: doc/BRIEF.md
# Binary Repetition Count Health Test

This block watches a one-bit raw entropy stream and flags a suspected source failure whenever the same bit value keeps arriving for too long. Every accepted sample is pushed into a window whose length equals the repetition cutoff. When that window is completely filled and holds only ones, or only zeros, the block raises an alarm. The block also passes on a gated copy of the sample strobe, so that downstream consumers stop taking samples while the alarm is up.

The cutoff is fixed when the design is built. It is computed from two parameters: the exponent of the accepted false-alarm probability (the probability is 2^-ALPHA_EXP) and the per-bit entropy estimate in units of 1/256 bit. The block has no recovery policy of its own. Forwarding of samples resumes on its own as soon as a differing bit breaks the run.

Top module: `rct_health_top`

## Requirements
- R1: While reset is asserted, and in the first cycle after reset, `alarm_o` is 0 and the sample window counts as empty.
- R2: `alarm_o` stays 0 until at least CUTOFF samples have been accepted since reset, even when every one of those samples is equal.
- R3: When the accepted sample presented with `sample_valid_i`=1 is the CUTOFF-th consecutive 1, `alarm_o` is 1 from the next clock edge on.
- R4: When the accepted sample presented with `sample_valid_i`=1 is the CUTOFF-th consecutive 0, `alarm_o` is 1 from the next clock edge on.
- R5: A run of at most CUTOFF-1 equal samples that is followed by a differing sample never raises `alarm_o`. An alternating stream never raises it either.
- R6: While the alarm is active, an accepted sample that differs from the previous accepted sample clears `alarm_o` at the next clock edge.
- R7: `valid_o` equals `sample_valid_i` AND NOT `alarm_o` in the same cycle. While the alarm is active, no sample is forwarded, including the sample that breaks the run.
- R8: Cycles with `sample_valid_i`=0 do not change the window or the alarm, whatever value `sample_bit_i` carries.
- R9: CUTOFF = 1 + ceil(ALPHA_EXP*256/ENT_Q8), with a floor of 2. The defaults (20, 256) give 21. A higher allowed false-alarm probability, for example ALPHA_EXP=10, gives a shorter cutoff (11).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| sample_valid_i | input | 1 | Strobe: `sample_bit_i` carries a new raw sample |
| sample_bit_i | input | 1 | Raw bit from the entropy source |
| alarm_o | output | 1 | Registered repetition alarm |
| valid_o | output | 1 | Sample strobe gated by the alarm |

## Verification
The properties assume that `rst_ni` is released in step with the clock. They also assume that the sample inputs change only between clock edges, so one strobe cycle stands for exactly one sample. The stimulus drives every input on the falling edge and starts each phase from a known reset. Two builds run side by side on the same stimulus, one with the default cutoff and one with a shorter cutoff. The runs of equal bits are placed just below, exactly at and beyond each of the two cutoffs. Idle cycles, with the bit input set to the opposite value, are mixed into a run so the checks can show they do not break it.

// File: rtl/rct_pkg.sv
package rct_pkg;

  // Entropy estimates are given in units of 1/256 bit.
  localparam int unsigned ENT_ONE = 256;

  // Repetition cutoff: 1 + ceil(alpha_exp / entropy), never below 2.
  function automatic int unsigned rct_cutoff(input int unsigned alpha_exp,
                                             input int unsigned ent_q8);
    int unsigned num;
    int unsigned res;
    num = alpha_exp * ENT_ONE;
    res = 1 + (num + ent_q8 - 1) / ent_q8;
    if (res < 2) res = 2;
    return res;
  endfunction

endpackage

// File: rtl/rct_window.sv
module rct_window #(
  parameter int unsigned DEPTH = 21
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             shift_en_i,
  input  logic             bit_i,
  output logic [DEPTH-1:0] win_nx_o,
  output logic             full_nx_o
);

  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [DEPTH-1:0] win_q, win_d;
  logic [CW-1:0]    cnt_q, cnt_d;

  // next state
  always_comb begin
    win_d = win_q;
    cnt_d = cnt_q;
    if (shift_en_i) begin
      win_d = {win_q[DEPTH-2:0], bit_i};
      if (cnt_q != FULL_CNT) cnt_d = cnt_q + CW'(1);
    end
  end

  // registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q <= '0;
      cnt_q <= '0;
    end else if (shift_en_i) begin
      win_q <= win_d;
      cnt_q <= cnt_d;
    end
  end

  assign win_nx_o  = win_d;
  assign full_nx_o = (cnt_d == FULL_CNT);

endmodule

// File: rtl/rct_uniform_detect.sv
module rct_uniform_detect #(
  parameter int unsigned DEPTH = 21
) (
  input  logic [DEPTH-1:0] vec_i,
  output logic             uniform_o
);

  logic all_one, all_zero;

  always_comb begin
    all_one   = &vec_i;
    all_zero  = ~(|vec_i);
    uniform_o = all_one | all_zero;
  end

endmodule

// File: rtl/rct_health_top.sv
module rct_health_top #(
  parameter int unsigned ALPHA_EXP = 20,
  parameter int unsigned ENT_Q8    = 256
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sample_valid_i,
  input  logic sample_bit_i,
  output logic alarm_o,
  output logic valid_o
);

  localparam int unsigned CUTOFF = rct_pkg::rct_cutoff(ALPHA_EXP, ENT_Q8);

  if (ENT_Q8 == 0 || ENT_Q8 > rct_pkg::ENT_ONE) begin : g_bad_entropy
    $error("ENT_Q8 must lie in 1..256");
  end

  logic [CUTOFF-1:0] win_nx;
  logic              full_nx;
  logic              uniform_nx;
  logic              alarm_q, alarm_d;

  rct_window #(.DEPTH(CUTOFF)) u_window (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .shift_en_i (sample_valid_i),
    .bit_i      (sample_bit_i),
    .win_nx_o   (win_nx),
    .full_nx_o  (full_nx)
  );

  rct_uniform_detect #(.DEPTH(CUTOFF)) u_detect (
    .vec_i     (win_nx),
    .uniform_o (uniform_nx)
  );

  // next state: the alarm follows the window content after this sample
  always_comb begin
    alarm_d = full_nx & uniform_nx;
  end

  // register, enabled by the sample strobe
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alarm_q <= 1'b0;
    end else if (sample_valid_i) begin
      alarm_q <= alarm_d;
    end
  end

  assign alarm_o = alarm_q;
  assign valid_o = sample_valid_i & ~alarm_q;

endmodule

// File: rtl/rct_health_chk.sv
module rct_health_chk #(
  parameter int unsigned CUTOFF = 21
) (
  input logic clk_i,
  input logic rst_ni,
  input logic sample_valid_i,
  input logic sample_bit_i,
  input logic alarm_o,
  input logic valid_o
);

  localparam int unsigned CW = $clog2(CUTOFF + 1);
  localparam logic [CW-1:0] CUT = CW'(CUTOFF);

  logic [CW-1:0] seen_q, run_q, run_nx;
  logic          last_q;

  // independent run-length view of the accepted stream
  always_comb begin
    run_nx = run_q;
    if (sample_valid_i) begin
      if (seen_q == '0 || sample_bit_i != last_q) run_nx = CW'(1);
      else if (run_q < CUT)                       run_nx = run_q + CW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= '0;
      run_q  <= '0;
      last_q <= 1'b0;
    end else if (sample_valid_i) begin
      if (seen_q < CUT) seen_q <= seen_q + CW'(1);
      run_q  <= run_nx;
      last_q <= sample_bit_i;
    end
  end

  // R2
  no_early_alarm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_o |-> (seen_q == CUT));

  // R3, R4
  run_alarm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_valid_i && run_nx == CUT) |=> alarm_o);

  // R6
  break_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_valid_i && seen_q != '0 && sample_bit_i != last_q) |=> !alarm_o);

  // R7
  gate_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_o |-> !valid_o);

  // R8
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_valid_i |=> $stable(alarm_o));

endmodule

bind rct_health_top rct_health_chk #(.CUTOFF(CUTOFF)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .sample_valid_i (sample_valid_i),
  .sample_bit_i   (sample_bit_i),
  .alarm_o        (alarm_o),
  .valid_o        (valid_o)
);

// File: tb/tb_rct_health_top.sv
`timescale 1ns/1ps
module tb_rct_health_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid_i = 1'b0;
  logic bit_i = 1'b0;
  logic alarm_a, vo_a, alarm_b, vo_b;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  rct_health_top dut (
    .clk_i(clk), .rst_ni(rst_n), .sample_valid_i(valid_i),
    .sample_bit_i(bit_i), .alarm_o(alarm_a), .valid_o(vo_a));

  // R9: ALPHA_EXP=10 must give cutoff 11
  rct_health_top #(.ALPHA_EXP(10), .ENT_Q8(256)) dut_short (
    .clk_i(clk), .rst_ni(rst_n), .sample_valid_i(valid_i),
    .sample_bit_i(bit_i), .alarm_o(alarm_b), .valid_o(vo_b));

  // reference model, from the requirements: [0]=default (21), [1]=short (11)
  int cut[2] = '{21, 11};
  int run[2];
  int cnt[2];
  bit last[2];
  bit m_alarm[2];

  // scoreboard queues
  bit    q_alarm[$];
  bit    q_vo[$];
  string q_tag[$];

  task automatic model_reset();
    for (int i = 0; i < 2; i++) begin
      run[i] = 0; cnt[i] = 0; last[i] = 1'b0; m_alarm[i] = 1'b0;
    end
  endtask

  task automatic check(input string tag, input string what, input bit act, input bit exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual %0b expected %0b", tag, what, act, exp);
    end
  endtask

  // driver: one cycle of stimulus, pushes expectations, then advances the model
  task automatic step(input bit v, input bit b, input string tag);
    @(negedge clk);
    valid_i = v;
    bit_i   = b;
    for (int i = 0; i < 2; i++) begin
      q_alarm.push_back(m_alarm[i]);
      q_vo.push_back(v & ~m_alarm[i]);
    end
    q_tag.push_back(tag);
    @(posedge clk);
    if (v) begin
      for (int i = 0; i < 2; i++) begin
        if (cnt[i] == 0 || b != last[i]) run[i] = 1;
        else if (run[i] < cut[i]) run[i]++;
        last[i] = b;
        cnt[i]++;
        m_alarm[i] = (run[i] >= cut[i]);
      end
    end
  endtask

  task automatic steps(input int n, input bit v, input bit b, input string tag);
    for (int k = 0; k < n; k++) step(v, b, tag);
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (q_tag.size() != 0) begin
        string t;
        t = q_tag.pop_front();
        check(t, "dut alarm_o", alarm_a, q_alarm.pop_front());
        check(t, "dut valid_o", vo_a, q_vo.pop_front());
        check(t, "dut_short alarm_o", alarm_b, q_alarm.pop_front());
        check(t, "dut_short valid_o", vo_b, q_vo.pop_front());
      end
    end
  end

  task automatic do_reset(input string tag);
    @(negedge clk);
    rst_n   = 1'b0;
    valid_i = 1'b1;
    bit_i   = 1'b1;
    model_reset();
    #1;
    check(tag, "dut alarm_o in reset", alarm_a, 1'b0);
    check(tag, "dut_short alarm_o in reset", alarm_b, 1'b0);
    @(negedge clk);
    valid_i = 1'b0;
    rst_n   = 1'b1;
  endtask

  initial begin
    model_reset();
    do_reset("R1");
    step(1'b0, 1'b0, "R1");

    // R2 / R9: 20 ones, short build alarms at 11, default stays quiet
    steps(20, 1'b1, 1'b1, "R2,R9");
    // R3: 21st one raises the default alarm
    step(1'b1, 1'b1, "R3");
    steps(3, 1'b1, 1'b1, "R7");
    // R6: differing sample is blocked and clears the alarm
    step(1'b1, 1'b0, "R6");
    steps(2, 1'b1, 1'b0, "R6");

    // R5: alternating stream
    do_reset("R1");
    for (int k = 0; k < 40; k++) step(1'b1, k[0], "R5");
    // R5: 20 zeros then a one, default never alarms
    do_reset("R1");
    steps(20, 1'b1, 1'b0, "R5");
    step(1'b1, 1'b1, "R5");
    steps(20, 1'b1, 1'b1, "R5");
    step(1'b1, 1'b0, "R5");

    // R4: 21 zeros
    do_reset("R1");
    steps(21, 1'b1, 1'b0, "R4");
    steps(2, 1'b1, 1'b0, "R4,R7");

    // R8: idle cycles with opposite bit inside a run of ones
    do_reset("R1");
    for (int k = 0; k < 21; k++) begin
      step(1'b1, 1'b1, "R8");
      step(1'b0, 1'b0, "R8");
    end
    steps(3, 1'b0, 1'b0, "R8");
    step(1'b1, 1'b0, "R6");
    steps(2, 1'b0, 1'b1, "R8");
    step(1'b1, 1'b0, "R7");

    // R1: reset while alarm active
    steps(25, 1'b1, 1'b0, "R4");
    do_reset("R1");
    step(1'b1, 1'b0, "R1");

    @(negedge clk);
    @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  // watchdog
  initial begin
    #1000000;
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule